// File: doc/BRIEF.md
# Motor Command Packet Decoder

This block sits behind a UART receiver in a motor drive controller. Received bytes go into a small ring buffer. A parser drains the buffer as fast as it can and frames the bytes into command packets. The first byte of each packet is a keycode, and the parser decides from it whether argument bytes follow, what reply goes back and which control action fires.

Four keycodes are recognised:

- A ping command answers with a fixed four-byte pattern and flips an indicator LED.
- A reset command raises a one-cycle soft-reset request.
- A speed-set command takes a signed 32-bit electrical speed, loads it into a target register and answers with one acknowledge byte.
- A speed-read command answers with the measured electrical speed as four bytes.

Replies leave on a byte stream with a valid/ready handshake. Every other byte value in keycode position is dropped without a reply.

Top module: `cmd_packet_decoder`

## Requirements
- R1: After synchronous reset, `tx_valid`, `speed_load`, `soft_reset_req`, `led_state` and `rx_overflow` are 0, and `speed_target` is 0.
- R2: Bytes presented on `rx_valid`/`rx_data` in consecutive cycles are held in a ring buffer of `DEPTH` entries. None of them is lost while the buffer has room, even when a reply is stalled.
- R3: A byte that arrives while the buffer holds `DEPTH` bytes is dropped and sets `rx_overflow`. `rx_overflow` stays 1 until reset.
- R4: Keycode 0x7F (127) produces the reply bytes 0x7F, 0x0C, 0x18, 0x30 in that order and inverts `led_state` once.
- R5: Keycode 0x80 (128) raises `soft_reset_req` for exactly one cycle and produces no reply.
- R6: Keycode 0x8D (141) is followed by four argument bytes, least significant first. `speed_target` takes the assembled value in the same cycle that `speed_load` pulses for one cycle. The pulse happens only after the fourth argument byte. The reply is the single byte 0x8D.
- R7: Keycode 0x8E (142) produces four reply bytes, least significant first, of `speed_now` as sampled in the cycle the keycode is decoded. Later changes of `speed_now` do not alter that reply.
- R8: A byte in keycode position that is none of 0x7F, 0x80, 0x8D, 0x8E is discarded with no reply and no action. The following byte is decoded as a keycode.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` is unchanged. A reply byte is consumed in a cycle where both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| speed_now | input | 32 | Measured electrical speed, two's complement |
| tx_valid | output | 1 | Reply byte available |
| tx_ready | input | 1 | Consumer accepts the reply byte |
| tx_data | output | 8 | Reply byte |
| speed_target | output | 32 | Commanded electrical speed |
| speed_load | output | 1 | One-cycle strobe when `speed_target` is updated |
| led_state | output | 1 | Indicator LED level |
| soft_reset_req | output | 1 | One-cycle soft-reset request |
| rx_overflow | output | 1 | Sticky flag for a byte dropped on a full buffer |

## Verification
Several properties are checked on every cycle:

- The buffer occupancy never passes its depth.
- A dropped byte leaves the occupancy untouched.
- The overflow flag never clears outside reset.
- A stalled reply byte stays put.
- Both strobes last one cycle.
- A speed load coincides with the acknowledge byte being offered.

Some behaviour only the bench scenarios can show. These are the exact reply contents and their byte order, the little-endian assembly of the speed argument, and the snapshot of the measured speed taken at decode. The same holds for silent discard of unknown keycodes, no loss of back-to-back packets queued behind a stalled reply, and the exact byte count at which the overflow flag rises.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam logic [7:0] KEY_PING      = 8'h7F;
  localparam logic [7:0] KEY_SOFTRST   = 8'h80;
  localparam logic [7:0] KEY_SPEED_SET = 8'h8D;
  localparam logic [7:0] KEY_SPEED_GET = 8'h8E;

  // ping reply, first byte in bits [7:0]
  localparam logic [31:0] PING_REPLY = 32'h3018_0C7F;

  typedef enum logic [1:0] {
    PS_KEY  = 2'd0,
    PS_ARG  = 2'd1,
    PS_SEND = 2'd2
  } parse_state_t;
endpackage

// File: rtl/cmd_byte_ring.sv
module cmd_byte_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         pop_req,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic          full, empty, do_wr, do_rd;

  assign full  = (count == FULL_LVL);
  assign empty = (count == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = pop_req && !empty;

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
    if (do_rd) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      rd_valid <= 1'b0;
      overflow <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      unique case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_en && full) overflow <= 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_LVL);                                               // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !pop_req) |=> (count == $past(count)));         // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);                                           // R3
endmodule

// File: rtl/cmd_parser.sv
module cmd_parser
  import cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  output logic        pop_req,
  input  logic [31:0] speed_now,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic [31:0] speed_target,
  output logic        speed_load,
  output logic        led_state,
  output logic        soft_reset_req
);
  parse_state_t state;
  logic [31:0]  reply_sh;
  logic [2:0]   reply_left;
  logic [31:0]  arg_sh;
  logic [1:0]   arg_idx;
  logic [31:0]  arg_full;

  // one byte in flight at most, so nothing arrives during a reply
  assign pop_req  = (state != PS_SEND) && !byte_valid;
  assign tx_data  = reply_sh[7:0];
  assign arg_full = {byte_data, arg_sh[31:8]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= PS_KEY;
      reply_sh       <= '0;
      reply_left     <= '0;
      arg_sh         <= '0;
      arg_idx        <= '0;
      tx_valid       <= 1'b0;
      speed_target   <= '0;
      speed_load     <= 1'b0;
      led_state      <= 1'b0;
      soft_reset_req <= 1'b0;
    end else begin
      speed_load     <= 1'b0;
      soft_reset_req <= 1'b0;
      unique case (state)
        PS_KEY: if (byte_valid) begin
          if (byte_data == KEY_PING) begin
            led_state  <= ~led_state;
            reply_sh   <= PING_REPLY;
            reply_left <= 3'd4;
            tx_valid   <= 1'b1;
            state      <= PS_SEND;
          end else if (byte_data == KEY_SOFTRST) begin
            soft_reset_req <= 1'b1;
          end else if (byte_data == KEY_SPEED_SET) begin
            arg_idx <= '0;
            state   <= PS_ARG;
          end else if (byte_data == KEY_SPEED_GET) begin
            reply_sh   <= speed_now;
            reply_left <= 3'd4;
            tx_valid   <= 1'b1;
            state      <= PS_SEND;
          end
        end
        PS_ARG: if (byte_valid) begin
          arg_sh  <= arg_full;
          arg_idx <= arg_idx + 1'b1;
          if (arg_idx == 2'd3) begin
            speed_target <= arg_full;
            speed_load   <= 1'b1;
            reply_sh     <= {24'd0, KEY_SPEED_SET};
            reply_left   <= 3'd1;
            tx_valid     <= 1'b1;
            state        <= PS_SEND;
          end
        end
        PS_SEND: if (tx_ready) begin
          if (reply_left == 3'd1) begin
            tx_valid <= 1'b0;
            state    <= PS_KEY;
          end else begin
            reply_sh   <= {8'd0, reply_sh[31:8]};
            reply_left <= reply_left - 1'b1;
          end
        end
        default: state <= PS_KEY;
      endcase
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));      // R9
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    speed_load |=> !speed_load);                                      // R6
  AST_LOAD_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    speed_load |-> (tx_valid && tx_data == KEY_SPEED_SET));           // R6
  AST_SOFTRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    soft_reset_req |=> !soft_reset_req);                              // R5
  AST_SOFTRST_SILENT: assert property (@(posedge clk) disable iff (rst)
    soft_reset_req |-> !tx_valid);                                    // R5
endmodule

// File: rtl/cmd_packet_decoder.sv
module cmd_packet_decoder #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic [31:0] speed_now,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic [31:0] speed_target,
  output logic        speed_load,
  output logic        led_state,
  output logic        soft_reset_req,
  output logic        rx_overflow
);
  logic       pop_req;
  logic       byte_valid;
  logic [7:0] byte_data;

  cmd_byte_ring #(.DEPTH(DEPTH), .W(8)) i_ring (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (rx_valid),
    .wr_data  (rx_data),
    .pop_req  (pop_req),
    .rd_valid (byte_valid),
    .rd_data  (byte_data),
    .overflow (rx_overflow)
  );

  cmd_parser i_parser (
    .clk            (clk),
    .rst            (rst),
    .byte_valid     (byte_valid),
    .byte_data      (byte_data),
    .pop_req        (pop_req),
    .speed_now      (speed_now),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .tx_data        (tx_data),
    .speed_target   (speed_target),
    .speed_load     (speed_load),
    .led_state      (led_state),
    .soft_reset_req (soft_reset_req)
  );
endmodule

// File: tb/test_cmd_packet_decoder.sv
module test_cmd_packet_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [31:0] speed_now = 32'hCAFE_1234;
  logic        tx_ready = 1'b1;
  logic        tx_valid, speed_load, led_state, soft_reset_req, rx_overflow;
  logic [7:0]  tx_data;
  logic [31:0] speed_target;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_packet_decoder #(.DEPTH(DEPTH)) i_cmd_packet_decoder (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .speed_now(speed_now), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .speed_target(speed_target), .speed_load(speed_load),
    .led_state(led_state), .soft_reset_req(soft_reset_req),
    .rx_overflow(rx_overflow)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] got [64];
  int n_got = 0;
  int n_load = 0;
  int n_srst = 0;
  logic led_exp = 1'b0;

  // vector table: packet bytes (first byte in [7:0]), length, reply, reply length
  localparam int NV = 7;
  localparam logic [39:0] V_PKT  [NV] = '{40'h7F, 40'h12345678_8D, 40'h8E, 40'h55,
                                          40'hFFFFFFFF_8D, 40'h7F, 40'h80};
  localparam int          V_PLEN [NV] = '{1, 5, 1, 1, 5, 1, 1};
  localparam logic [31:0] V_REP  [NV] = '{32'h30180C7F, 32'h8D, 32'hCAFE1234, 32'h0,
                                          32'h8D, 32'h30180C7F, 32'h0};
  localparam int          V_RLEN [NV] = '{4, 1, 4, 0, 1, 4, 0};

  // sampling away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_valid && tx_ready && n_got < 64) begin
        got[n_got] = tx_data;
        n_got = n_got + 1;
      end
      if (speed_load) n_load = n_load + 1;
      if (soft_reset_req) n_srst = n_srst + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [39:0] pkt, input int len);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b1;
      rx_data  = pkt[8*i +: 8];
    end
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_obs();
    n_got = 0; n_load = 0; n_srst = 0;
  endtask

  function automatic string tag_of(input logic [7:0] k);
    case (k)
      8'h7F:   return "R4";
      8'h80:   return "R5";
      8'h8D:   return "R6";
      8'h8E:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic do_reset();
    @(posedge clk); #1; rst = 1'b1;
    wait_cycles(3);
    rst = 1'b0;
    led_exp = 1'b0;
    clear_obs();
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    wait_cycles(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 tx_valid", tx_valid, 0);
    check("R1 speed_target", speed_target, 0);
    check("R1 led_state", led_state, 0);
    check("R1 rx_overflow", rx_overflow, 0);
    check("R1 strobes", {speed_load, soft_reset_req}, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      clear_obs();
      send(V_PKT[v], V_PLEN[v]);
      wait_cycles(40);
      if (V_PKT[v][7:0] == 8'h7F) led_exp = ~led_exp;
      check({tag_of(V_PKT[v][7:0]), " reply length"}, n_got, V_RLEN[v]);
      for (int b = 0; b < V_RLEN[v]; b++)
        check({tag_of(V_PKT[v][7:0]), " reply byte"}, got[b], V_REP[v][8*b +: 8]);
      check("R4 led_state", led_state, led_exp);
      if (V_PKT[v][7:0] == 8'h8D) begin
        check("R6 load pulses", n_load, 1);
        check("R6 speed_target", speed_target, V_PKT[v][39:8]);
      end else begin
        check({tag_of(V_PKT[v][7:0]), " no load"}, n_load, 0);
      end
      check({tag_of(V_PKT[v][7:0]), " soft reset pulses"}, n_srst,
            (V_PKT[v][7:0] == 8'h80) ? 1 : 0);
    end

    // R6 no strobe before the fourth argument byte
    clear_obs();
    send(40'h00332211_8D, 4);
    wait_cycles(20);
    check("R6 no early load", n_load, 0);
    check("R6 no early ack", n_got, 0);
    send(40'h44, 1);
    wait_cycles(20);
    check("R6 load after fourth", n_load, 1);
    check("R6 target value", speed_target, 32'h44332211);

    // R8 unknown keycode followed directly by a ping
    clear_obs();
    send(40'h7F_55, 2);
    wait_cycles(30);
    led_exp = ~led_exp;
    check("R8 next byte decoded", n_got, 4);
    check("R8 ping first byte", got[0], 8'h7F);

    // R9 backpressure and R7 snapshot
    clear_obs();
    tx_ready = 1'b0;
    speed_now = 32'h0102_A0B0;
    send(40'h8E, 1);
    wait_cycles(5);
    speed_now = 32'hDEAD_BEEF;
    check("R9 valid held", tx_valid, 1);
    check("R9 data held", tx_data, 8'hB0);
    wait_cycles(10);
    check("R9 still held", {tx_valid, tx_data}, {1'b1, 8'hB0});
    check("R9 nothing consumed", n_got, 0);
    tx_ready = 1'b1;
    wait_cycles(20);
    check("R7 snapshot length", n_got, 4);
    check("R7 snapshot value", {got[3], got[2], got[1], got[0]}, 32'h0102_A0B0);

    // R2 back-to-back packets queued behind a stalled reply
    clear_obs();
    tx_ready = 1'b0;
    send(40'h7F, 1);
    send(40'h0A0B0C0D_8D, 5);
    wait_cycles(10);
    tx_ready = 1'b1;
    wait_cycles(40);
    led_exp = ~led_exp;
    check("R2 total bytes", n_got, 5);
    check("R2 ack after ping", got[4], 8'h8D);
    check("R2 target", speed_target, 32'h0A0B0C0D);

    // R3 overflow
    clear_obs();
    tx_ready = 1'b0;
    send(40'h7F, 1);
    wait_cycles(5);
    for (int i = 0; i < DEPTH; i++) send(40'h00, 1);
    @(negedge clk);
    check("R3 no overflow at depth", rx_overflow, 0);
    send(40'h00, 1);
    @(negedge clk);
    check("R3 overflow set", rx_overflow, 1);
    tx_ready = 1'b1;
    wait_cycles(100);
    check("R3 overflow sticky", rx_overflow, 1);
    check("R3 drained reply", n_got, 4);
    do_reset();
    @(negedge clk);
    check("R3 cleared by reset", rx_overflow, 0);
    check("R1 led after reset", led_state, 0);

    summary();
  end
endmodule